// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block sits on the host side of a flash device and works out whether an embedded program or erase operation has finished. When pulsed to start, it reads the device's status byte twice in a row over a simple request/acknowledge bus. It then compares the toggle bit (bit 6) of the two reads. A stable toggle bit means the operation is over. A moving toggle bit means the device is still working, unless the timing-limit flag (bit 5) is raised.

When the limit flag is seen, a single pair of samples is not enough to decide. The toggle bit may stop at the very moment the flag rises. The poller therefore takes a fresh pair of reads. If the toggle has stopped, it reports completion. If it is still moving, it writes the reset command (0xF0) so the device goes back to array reads, and reports failure once that write is acknowledged. A host-side limit on the number of busy read pairs stops the poll with a timeout result if the device never settles.

Every accepted start begins from a brand-new read pair, with no carry-over. An abandoned or timed-out poll can therefore be resumed simply by starting again.

Top module: `flash_toggle_poller`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `bus_rd`, `bus_wr` and `res_valid` are all 0.
- R2: Every status read drives `bus_addr` = `STAT_ADDR` with `bus_rd` high. A strobe stays high until the cycle in which `bus_ack` is 1, and `bus_rd` and `bus_wr` are never high together.
- R3: If bit 6 is equal in both reads of a pair, the poll ends with result code 0 (complete). No write is issued.
- R4: If bit 6 differs across a pair and bit 5 of the second read is 0, the poller issues another read pair.
- R5: If bit 6 differs across a pair and bit 5 of the second read is 1, the poller takes two further reads. If bit 6 is then equal across those two reads, the result is code 0 with no write.
- R6: If bit 6 still differs on that recheck, the poller writes data 0xF0 to `RST_ADDR`. It reports code 1 (failed) only after that write is acknowledged.
- R7: After `MAX_PAIRS` consecutive busy pairs (toggling, bit 5 = 0), the poll ends with code 2 (timeout). No write is issued.
- R8: A `start` pulse while `busy` is 1 is ignored. Each accepted start yields exactly one result.
- R9: Each accepted start begins at the first read of a new pair, with the busy-pair count cleared.
- R10: `res_valid` is a one-cycle pulse, and `busy` is 0 in that cycle.
- R11: Status bits other than 6 and 5 have no influence on the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a poll |
| bus_rdata | input | DW | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | One-cycle completion of the current access |
| bus_addr | output | AW | Access address |
| bus_rd | output | 1 | Read strobe, held until acknowledged |
| bus_wr | output | 1 | Write strobe, held until acknowledged |
| bus_wdata | output | DW | Write data (reset command) |
| res_valid | output | 1 | Result pulse |
| res_code | output | 2 | 0 complete, 1 failed, 2 timeout |
| busy | output | 1 | Poll in progress |

## Verification
The sharpest case is a pair that shows the limit flag followed by a recheck where the toggle has stopped. A poller that trusts the first sample would wrongly write the reset command and report failure. The bench also pushes exactly `MAX_PAIRS` busy pairs to catch an off-by-one timeout. It then resumes with fewer busy pairs, so a counter that is not cleared would time out early. Further stimuli flip unrelated status bits, which a poller comparing the whole byte would misread as busy. A second start is pulsed mid-poll, where a poller that restarted would issue extra reads or two results. Read latency is varied, so that a poller sampling data before the acknowledge, or dropping its strobe early, reads the wrong word.

// File: rtl/ftp_pkg.sv
// Package: shared state and result encodings of the toggle-bit poller.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package ftp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_A,
        ST_RD_B,
        ST_RC_A,
        ST_RC_B,
        ST_WR_RST
    } poll_st_e;

    typedef enum logic [1:0] {
        RES_DONE = 2'd0,
        RES_FAIL = 2'd1,
        RES_TMO  = 2'd2
    } poll_res_e;

endpackage

// File: rtl/status_cmp.sv
// Module: status_cmp
// Compares two status samples: flags a change of the toggle bit and
// reports the timing-limit flag taken from the second sample.
// Assumes: both bit indices lie inside DW.
module status_cmp #(
    parameter int DW      = 8,
    parameter int TOG_BIT = 6,
    parameter int LIM_BIT = 5
) (
    input  logic [DW-1:0] first_smp,
    input  logic [DW-1:0] second_smp,
    output logic          toggled,
    output logic          limit_hit
);

    // Purpose: extract only the two status bits that matter.
    always_comb begin
        toggled   = first_smp[TOG_BIT] ^ second_smp[TOG_BIT];
        limit_hit = second_smp[LIM_BIT];
    end

endmodule

// File: rtl/pair_counter.sv
// Module: pair_counter
// Counts busy read pairs of one poll and flags the last permitted one.
// Assumes: MAX_PAIRS >= 1; clr and inc are never high together.
module pair_counter #(
    parameter int MAX_PAIRS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);

    localparam int CW = (MAX_PAIRS > 1) ? $clog2(MAX_PAIRS) : 1;
    localparam logic [CW-1:0] LAST_VAL = CW'(MAX_PAIRS - 1);

    logic [CW-1:0] cnt_q;

    // Purpose: clear at each accepted start, advance on each busy pair.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != LAST_VAL)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Purpose: terminal flag for the pair now being judged.
    always_comb last = (cnt_q == LAST_VAL);

endmodule

// File: rtl/poll_seq.sv
// Module: poll_seq
// Sequencer of the poll: read pair, optional recheck pair, optional
// reset-command write, then a one-cycle result.
// Assumes: bus_ack only arrives while a strobe is high; the read data
// is valid in the acknowledge cycle.
module poll_seq
    import ftp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          bus_ack,
    input  logic [DW-1:0] bus_rdata,
    input  logic          toggled,
    input  logic          limit_hit,
    input  logic          cnt_last,
    output logic          cnt_clr,
    output logic          cnt_inc,
    output logic [DW-1:0] first_q,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic          res_valid,
    output logic [1:0]    res_code,
    output logic          busy
);

    poll_st_e state_q;

    // Purpose: state transitions, sample capture and result registration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            first_q   <= '0;
            res_valid <= 1'b0;
            res_code  <= RES_DONE;
        end else begin
            res_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_RD_A;
                        first_q <= '0;
                    end
                end
                ST_RD_A: begin
                    if (bus_ack) begin
                        first_q <= bus_rdata;
                        state_q <= ST_RD_B;
                    end
                end
                ST_RD_B: begin
                    if (bus_ack) begin
                        if (!toggled) begin
                            state_q   <= ST_IDLE;
                            res_valid <= 1'b1;
                            res_code  <= RES_DONE;
                        end else if (!limit_hit) begin
                            if (cnt_last) begin
                                state_q   <= ST_IDLE;
                                res_valid <= 1'b1;
                                res_code  <= RES_TMO;
                            end else begin
                                state_q <= ST_RD_A;
                            end
                        end else begin
                            state_q <= ST_RC_A;
                        end
                    end
                end
                ST_RC_A: begin
                    if (bus_ack) begin
                        first_q <= bus_rdata;
                        state_q <= ST_RC_B;
                    end
                end
                ST_RC_B: begin
                    if (bus_ack) begin
                        if (!toggled) begin
                            state_q   <= ST_IDLE;
                            res_valid <= 1'b1;
                            res_code  <= RES_DONE;
                        end else begin
                            state_q <= ST_WR_RST;
                        end
                    end
                end
                ST_WR_RST: begin
                    if (bus_ack) begin
                        state_q   <= ST_IDLE;
                        res_valid <= 1'b1;
                        res_code  <= RES_FAIL;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Purpose: strobes, busy flag and counter controls decoded from state.
    always_comb begin
        bus_rd  = (state_q == ST_RD_A) || (state_q == ST_RD_B) ||
                  (state_q == ST_RC_A) || (state_q == ST_RC_B);
        bus_wr  = (state_q == ST_WR_RST);
        busy    = (state_q != ST_IDLE);
        cnt_clr = (state_q == ST_IDLE) && start;
        cnt_inc = (state_q == ST_RD_B) && bus_ack && toggled && !limit_hit;
    end

endmodule

// File: rtl/flash_toggle_poller.sv
// Module: flash_toggle_poller (top)
// Host-side completion poller for flash program/erase operations, using
// the toggle bit and the timing-limit flag of the status byte.
// Assumes: DW >= 8 so the reset command fits; a single outstanding access.
module flash_toggle_poller #(
    parameter int              DW        = 8,
    parameter int              AW        = 12,
    parameter int              MAX_PAIRS = 8,
    parameter int              TOG_BIT   = 6,
    parameter int              LIM_BIT   = 5,
    parameter logic [AW-1:0]   STAT_ADDR = 12'h100,
    parameter logic [AW-1:0]   RST_ADDR  = 12'h555,
    parameter logic [DW-1:0]   RST_DATA  = 8'hF0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ack,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [DW-1:0] bus_wdata,
    output logic          res_valid,
    output logic [1:0]    res_code,
    output logic          busy
);

    logic          toggled;
    logic          limit_hit;
    logic          cnt_last;
    logic          cnt_clr;
    logic          cnt_inc;
    logic [DW-1:0] first_q;

    status_cmp #(
        .DW      (DW),
        .TOG_BIT (TOG_BIT),
        .LIM_BIT (LIM_BIT)
    ) u_cmp (
        .first_smp  (first_q),
        .second_smp (bus_rdata),
        .toggled    (toggled),
        .limit_hit  (limit_hit)
    );

    pair_counter #(
        .MAX_PAIRS (MAX_PAIRS)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .last  (cnt_last)
    );

    poll_seq #(
        .DW (DW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata),
        .toggled   (toggled),
        .limit_hit (limit_hit),
        .cnt_last  (cnt_last),
        .cnt_clr   (cnt_clr),
        .cnt_inc   (cnt_inc),
        .first_q   (first_q),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .res_valid (res_valid),
        .res_code  (res_code),
        .busy      (busy)
    );

    // Purpose: address and write data follow the kind of access in flight.
    always_comb begin
        bus_addr  = bus_wr ? RST_ADDR : STAT_ADDR;
        bus_wdata = bus_wr ? RST_DATA : '0;
    end

endmodule

// File: rtl/ftp_checker.sv
// Module: ftp_checker
// Protocol and result properties of flash_toggle_poller, bound to the top.
// Assumes: sampled on the rising edge, disabled while reset is low.
module ftp_checker #(
    parameter int            DW        = 8,
    parameter int            AW        = 12,
    parameter logic [AW-1:0] STAT_ADDR = 12'h100,
    parameter logic [AW-1:0] RST_ADDR  = 12'h555,
    parameter logic [DW-1:0] RST_DATA  = 8'hF0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_ack,
    input logic [AW-1:0] bus_addr,
    input logic          bus_rd,
    input logic          bus_wr,
    input logic [DW-1:0] bus_wdata,
    input logic          res_valid,
    input logic [1:0]    res_code,
    input logic          busy
);

    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    a_r2_read_addr: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> (bus_addr == STAT_ADDR));

    a_r2_rd_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_ack) |=> bus_rd);

    a_r2_wr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_ack) |=> bus_wr);

    a_r6_reset_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> (bus_addr == RST_ADDR && bus_wdata == RST_DATA));

    a_r6_fail_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_code == 2'd1) |-> $past(bus_wr && bus_ack));

    a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    a_r10_idle_on_result: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !busy);

    a_r7_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_code != 2'd3));

endmodule

bind flash_toggle_poller ftp_checker #(
    .DW        (DW),
    .AW        (AW),
    .STAT_ADDR (STAT_ADDR),
    .RST_ADDR  (RST_ADDR),
    .RST_DATA  (RST_DATA)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_ack   (bus_ack),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .res_valid (res_valid),
    .res_code  (res_code),
    .busy      (busy)
);

// File: tb/flash_toggle_poller_bench.sv
// Bench: behavioural flash status responder plus per-scenario expectations.
module flash_toggle_poller_bench;

    localparam int            DW   = 8;
    localparam int            AW   = 12;
    localparam int            MAXP = 4;
    localparam logic [AW-1:0] SADR = 12'h100;
    localparam logic [AW-1:0] RADR = 12'h555;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [DW-1:0] bus_rdata = '0;
    logic          bus_ack = 1'b0;
    logic [AW-1:0] bus_addr;
    logic          bus_rd;
    logic          bus_wr;
    logic [DW-1:0] bus_wdata;
    logic          res_valid;
    logic [1:0]    res_code;
    logic          busy;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    int lat = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int pulse_cnt = 0;
    logic [DW-1:0] last_wd = '0;
    logic [AW-1:0] last_wa = '0;
    logic [DW-1:0] q[$];

    always #2.5 clk = ~clk;

    flash_toggle_poller #(
        .DW (DW), .AW (AW), .MAX_PAIRS (MAXP),
        .STAT_ADDR (SADR), .RST_ADDR (RADR), .RST_DATA (8'hF0)
    ) u_flash_toggle_poller (
        .clk (clk), .rst_n (rst_n), .start (start),
        .bus_rdata (bus_rdata), .bus_ack (bus_ack),
        .bus_addr (bus_addr), .bus_rd (bus_rd), .bus_wr (bus_wr),
        .bus_wdata (bus_wdata), .res_valid (res_valid),
        .res_code (res_code), .busy (busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Flash status responder, plus per-clock checks of the strobes (R2, R10).
    initial begin
        int wcnt;
        wcnt = 0;
        forever begin
            @(negedge clk);
            cycles++;
            if (rst_n) begin
                chk(!(bus_rd && bus_wr), "R2 strobes", int'(bus_rd && bus_wr), 0);
                if (res_valid) begin
                    pulse_cnt++;
                    chk(!busy, "R10 busy with result", int'(busy), 0);
                end
            end
            if (bus_ack) begin
                bus_ack = 1'b0;
                wcnt = 0;
            end else if (rst_n && (bus_rd || bus_wr)) begin
                if (wcnt >= lat) begin
                    bus_ack = 1'b1;
                    if (bus_rd) begin
                        rd_cnt++;
                        chk(bus_addr == SADR, "R2 read addr", int'(bus_addr), int'(SADR));
                        if (q.size() > 0) bus_rdata = q.pop_front();
                        else bus_rdata = 8'h00;
                    end else begin
                        wr_cnt++;
                        last_wd = bus_wdata;
                        last_wa = bus_addr;
                    end
                end else begin
                    wcnt++;
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        wait (cycles > 100000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    task automatic run(input int lat_i, input bit dbl, input int exp_code,
                       input int exp_rd, input int exp_wr, input string req);
        int n;
        int p0;
        lat = lat_i;
        rd_cnt = 0;
        wr_cnt = 0;
        p0 = pulse_cnt;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, {req, " busy after start"}, int'(busy), 1);
        n = 0;
        while (!res_valid && n < 2000) begin
            @(negedge clk);
            n++;
            if (dbl && n == 3) start = 1'b1;
            if (dbl && n == 4) start = 1'b0;
        end
        chk(res_valid, {req, " result seen"}, int'(res_valid), 1);
        chk(res_code == exp_code[1:0], {req, " code"}, int'(res_code), exp_code);
        repeat (3) @(negedge clk);
        chk(pulse_cnt - p0 == 1, {req, " result count"}, pulse_cnt - p0, 1);
        chk(rd_cnt == exp_rd, {req, " reads"}, rd_cnt, exp_rd);
        chk(wr_cnt == exp_wr, {req, " writes"}, wr_cnt, exp_wr);
        if (exp_wr > 0) begin
            chk(last_wd == 8'hF0, {req, " reset data"}, int'(last_wd), 'hF0);
            chk(last_wa == RADR, {req, " reset addr"}, int'(last_wa), int'(RADR));
        end
        chk(!busy, {req, " idle after"}, int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !bus_rd && !bus_wr && !res_valid, "R1 in reset",
            int'({busy, bus_rd, bus_wr, res_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !bus_rd && !bus_wr && !res_valid, "R1 after reset",
            int'({busy, bus_rd, bus_wr, res_valid}), 0);

        // R3: stable toggle bit on first pair
        q = {8'h00, 8'h00};
        run(0, 1'b0, 0, 2, 0, "R3");
        // R11: other bits differ, bit 6 steady
        q = {8'hC0, 8'h7F};
        run(1, 1'b0, 0, 2, 0, "R11");
        // R4: one busy pair then stable
        q = {8'h40, 8'h00, 8'h00, 8'h00};
        run(2, 1'b0, 0, 4, 0, "R4");
        // R5: limit flag, recheck shows toggle stopped
        q = {8'h60, 8'h20, 8'h20, 8'h20};
        run(1, 1'b0, 0, 4, 0, "R5");
        // R6: busy pair, limit flag, recheck still toggling
        q = {8'h40, 8'h00, 8'h60, 8'h20, 8'h60, 8'h20};
        run(3, 1'b0, 1, 6, 1, "R6");
        // R7: exactly MAXP busy pairs
        q = {8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40};
        run(0, 1'b0, 2, 8, 0, "R7");
        // R9: resume after timeout, MAXP-1 busy pairs then stable
        q = {8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h00, 8'h00};
        run(1, 1'b0, 0, 8, 0, "R9");
        // R8: second start mid-poll ignored
        q = {8'h40, 8'h00, 8'h40, 8'h00, 8'h00, 8'h00};
        run(2, 1'b1, 0, 6, 0, "R8");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule